// File: doc/BRIEF.md
# USB Bus State and Frame Monitor

This block sits behind a full-speed USB receiver and turns its decoded line state and start-of-frame events into latched interrupt flags. It times single-ended zero to recognise a bus reset and times the idle (J) state to recognise suspend. It tracks the suspended state so that a K state during suspend is reported as resume. It records every received start-of-frame packet together with its 11-bit frame number.

When a start-of-frame packet fails to arrive within the expected frame period plus a small slack, the block produces an artificial start of frame itself. That event has its own flag and advances the local frame number modulo 2048. Each new frame number, whether received or synthesized, is compared against a programmable compare value.

All flags are sticky and cleared by write-one-to-clear strobes. A per-flag mask gates them onto a single interrupt line. All durations are parameters counted in clock cycles. With the defaults (12 MHz clock) they correspond to just over 2.5 µs, 3 ms, 1 ms and a few bit times.

Top module: `usb_bus_monitor`

## Requirements
- R1: Line state is encoded 00 = SE0, 01 = J, 10 = K, 11 = SE1. After RST_CYC consecutive SE0 samples, the bus-reset flag (flags bit 0) is set. It is set once per unbroken SE0 episode. A shorter SE0 run sets nothing.
- R2: After IDLE_CYC consecutive J samples, the block enters the suspended state and sets the suspend flag (bit 1). Any non-J sample restarts the idle count.
- R3: A K sample while suspended sets the resume flag (bit 2) and leaves the suspended state. A K sample while not suspended has no effect.
- R4: A usr_resume pulse sets the resume flag.
- R5: A detected bus reset leaves the suspended state, so a later K sample does not signal resume.
- R6: A sof_stb pulse sets the SOF flag (bit 3) and loads sof_frame into frame_num on the next clock. frame_num is 0 after reset.
- R7: The artificial-SOF timer is armed by the first received SOF. If FRAME_CYC+SOF_SLACK cycles pass with no SOF, the block:
  - sets the artificial-SOF flag (bit 4);
  - advances frame_num by one modulo 2048.
  Further artificial SOFs then follow every FRAME_CYC cycles.
- R8: Whenever frame_num takes a new value from a received or artificial SOF and that value equals frm_cmp, the frame-match flag (bit 5) is set.
- R9: All flags are 0 after reset. A flag stays set until a 1 is written to its flag_clr bit. A set event in the same cycle as its clear wins.
- R10: irq is high exactly when some flag is set and its flag_mask bit is 1.
- R11: A bus reset or entry into suspend disarms the artificial-SOF timer until the next received SOF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (12 MHz bit-rate tick by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st | input | 2 | Sampled line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| sof_stb | input | 1 | One-cycle strobe: a valid SOF packet was received |
| sof_frame | input | 11 | Frame number carried by the received SOF |
| usr_resume | input | 1 | Locally initiated resume request |
| frm_cmp | input | 11 | Frame number to match against |
| flag_mask | input | 6 | Per-flag interrupt enable |
| flag_clr | input | 6 | Write-one-to-clear strobes, one per flag |
| flags | output | 6 | Sticky flags: 0 reset, 1 suspend, 2 resume, 3 SOF, 4 artificial SOF, 5 frame match |
| irq | output | 1 | Combined masked interrupt |
| frame_num | output | 11 | Current frame number |

## Verification
The hardest situations to reach are the long-timeout events: artificial SOF generation and its wrap from frame 2047 to 0, and suspend followed by resume or reset. With default timings they take tens of thousands of cycles. The bench therefore shrinks RST_CYC, IDLE_CYC, FRAME_CYC and SOF_SLACK to small values. It parks the line in K so that no timer runs in the background. It then drives exact runs of SE0, J and K to land on the cycle before and the cycle of each threshold. For the artificial SOF, a received frame 2047 is followed by silence, and frm_cmp is set to 0. This shows the wrap and the frame-match flag from a synthesized frame.

// File: rtl/usb_mon_pkg.sv
package usb_mon_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  localparam int FRAME_W = 11;
  localparam int NFLAG   = 6;

  localparam int FL_RESET  = 0;
  localparam int FL_SUSP   = 1;
  localparam int FL_RESUME = 2;
  localparam int FL_SOF    = 3;
  localparam int FL_ASOF   = 4;
  localparam int FL_MATCH  = 5;
endpackage

// File: rtl/usb_line_watch.sv
module usb_line_watch
  import usb_mon_pkg::*;
#(
  parameter int RST_CYC  = 31,
  parameter int IDLE_CYC = 36000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  input  logic       usr_resume,
  output logic       rst_hit,
  output logic       susp_hit,
  output logic       resume_hit,
  output logic       suspended
);
  localparam int SW = $clog2(RST_CYC + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [SW-1:0] se0_cnt, se0_cnt_nxt;
  logic [IW-1:0] idle_cnt, idle_cnt_nxt;
  logic          susp_nxt;
  logic          is_se0, is_j, is_k;

  assign is_se0 = (line_st == LS_SE0);
  assign is_j   = (line_st == LS_J);
  assign is_k   = (line_st == LS_K);

  assign rst_hit    = is_se0 && (se0_cnt == SW'(RST_CYC - 1));
  assign susp_hit   = is_j && !suspended && (idle_cnt == IW'(IDLE_CYC - 1));
  assign resume_hit = (suspended && is_k) || usr_resume;

  always_comb begin
    se0_cnt_nxt = se0_cnt;
    if (!is_se0)
      se0_cnt_nxt = '0;
    else if (se0_cnt != SW'(RST_CYC))
      se0_cnt_nxt = se0_cnt + 1'b1;

    idle_cnt_nxt = idle_cnt;
    if (!is_j)
      idle_cnt_nxt = '0;
    else if (idle_cnt != IW'(IDLE_CYC))
      idle_cnt_nxt = idle_cnt + 1'b1;

    susp_nxt = suspended;
    if (rst_hit)
      susp_nxt = 1'b0;
    else if (susp_hit)
      susp_nxt = 1'b1;
    else if (resume_hit)
      susp_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se0_cnt   <= '0;
      idle_cnt  <= '0;
      suspended <= 1'b0;
    end else begin
      se0_cnt   <= se0_cnt_nxt;
      idle_cnt  <= idle_cnt_nxt;
      suspended <= susp_nxt;
    end
  end
endmodule

// File: rtl/usb_frame_track.sv
module usb_frame_track
  import usb_mon_pkg::*;
#(
  parameter int FRAME_CYC = 12000,
  parameter int SOF_SLACK = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_stb,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic [FRAME_W-1:0] frm_cmp,
  input  logic               disarm,
  output logic               asof_hit,
  output logic               match_hit,
  output logic [FRAME_W-1:0] frame_num
);
  localparam int LIMIT = FRAME_CYC + SOF_SLACK;
  localparam int TW    = $clog2(LIMIT + 1);

  logic [TW-1:0]      tmr, tmr_nxt;
  logic               armed, armed_nxt;
  logic [FRAME_W-1:0] frame_nxt;

  assign asof_hit  = armed && !sof_stb && (tmr == TW'(LIMIT - 1));
  assign match_hit = (sof_stb || asof_hit) && (frame_nxt == frm_cmp);

  always_comb begin
    frame_nxt = frame_num;
    if (sof_stb)
      frame_nxt = sof_frame;
    else if (asof_hit)
      frame_nxt = frame_num + 1'b1;

    tmr_nxt = '0;
    if (sof_stb)
      tmr_nxt = '0;
    else if (asof_hit)
      tmr_nxt = TW'(SOF_SLACK);
    else if (armed)
      tmr_nxt = tmr + 1'b1;

    armed_nxt = armed;
    if (disarm)
      armed_nxt = 1'b0;
    else if (sof_stb)
      armed_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr       <= '0;
      armed     <= 1'b0;
      frame_num <= '0;
    end else begin
      tmr       <= tmr_nxt;
      armed     <= armed_nxt;
      frame_num <= frame_nxt;
    end
  end
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_comb begin
        flags_nxt[i] = flags[i];
        if (set[i])
          flags_nxt[i] = 1'b1;
        else if (clr[i])
          flags_nxt[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= '0;
    else
      flags <= flags_nxt;
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/usb_bus_monitor.sv
module usb_bus_monitor
  import usb_mon_pkg::*;
#(
  parameter int RST_CYC   = 31,
  parameter int IDLE_CYC  = 36000,
  parameter int FRAME_CYC = 12000,
  parameter int SOF_SLACK = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         line_st,
  input  logic               sof_stb,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic               usr_resume,
  input  logic [FRAME_W-1:0] frm_cmp,
  input  logic [NFLAG-1:0]   flag_mask,
  input  logic [NFLAG-1:0]   flag_clr,
  output logic [NFLAG-1:0]   flags,
  output logic               irq,
  output logic [FRAME_W-1:0] frame_num
);
  logic rst_hit, susp_hit, resume_hit, suspended;
  logic asof_hit, match_hit;
  logic [NFLAG-1:0] set_vec;

  usb_line_watch #(.RST_CYC(RST_CYC), .IDLE_CYC(IDLE_CYC)) u_line (
    .clk(clk), .rst_n(rst_n), .line_st(line_st), .usr_resume(usr_resume),
    .rst_hit(rst_hit), .susp_hit(susp_hit), .resume_hit(resume_hit),
    .suspended(suspended)
  );

  usb_frame_track #(.FRAME_CYC(FRAME_CYC), .SOF_SLACK(SOF_SLACK)) u_frame (
    .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .sof_frame(sof_frame),
    .frm_cmp(frm_cmp), .disarm(rst_hit || susp_hit),
    .asof_hit(asof_hit), .match_hit(match_hit), .frame_num(frame_num)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FL_RESET]  = rst_hit;
    set_vec[FL_SUSP]   = susp_hit;
    set_vec[FL_RESUME] = resume_hit;
    set_vec[FL_SOF]    = sof_stb;
    set_vec[FL_ASOF]   = asof_hit;
    set_vec[FL_MATCH]  = match_hit;
  end

  usb_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(flag_clr),
    .mask(flag_mask), .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/usb_bus_monitor_chk.sv
module usb_bus_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sof_stb,
  input logic [10:0] sof_frame,
  input logic        usr_resume,
  input logic [5:0]  flag_clr,
  input logic [5:0]  flags,
  input logic [10:0] frame_num,
  input logic        rst_hit,
  input logic        susp_hit,
  input logic        resume_hit,
  input logic        suspended,
  input logic        asof_hit
);
  AST_RESET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> flags[0]); // R1
  AST_SUSP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    susp_hit |=> (suspended && flags[1])); // R2
  AST_RESUME_ONLY_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_hit && !usr_resume) |-> suspended); // R3
  AST_USR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    usr_resume |=> flags[2]); // R4
  AST_RESET_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> !suspended); // R5
  AST_SOF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sof_stb |=> (flags[3] && frame_num == $past(sof_frame))); // R6
  AST_ASOF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    asof_hit |=> (flags[4] && frame_num == 11'($past(frame_num) + 11'd1))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~flag_clr) != 6'd0) |=>
      ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr))); // R9
endmodule

bind usb_bus_monitor usb_bus_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .sof_frame(sof_frame),
  .usr_resume(usr_resume), .flag_clr(flag_clr), .flags(flags),
  .frame_num(frame_num), .rst_hit(rst_hit), .susp_hit(susp_hit),
  .resume_hit(resume_hit), .suspended(suspended), .asof_hit(asof_hit)
);

// File: tb/usb_bus_monitor_test.sv
module usb_bus_monitor_test;
  localparam int RST_CYC   = 8;
  localparam int IDLE_CYC  = 40;
  localparam int FRAME_CYC = 50;
  localparam int SOF_SLACK = 4;
  localparam int LIMIT     = FRAME_CYC + SOF_SLACK;

  localparam logic [1:0] SE0 = 2'b00, LJ = 2'b01, LK = 2'b10;

  // {sof frame, compare value, expected match}
  localparam logic [22:0] VEC [0:4] = '{
    {11'd5,    11'd5,    1'b1},
    {11'd5,    11'd6,    1'b0},
    {11'd2047, 11'd2047, 1'b1},
    {11'd0,    11'd1024, 1'b0},
    {11'd1024, 11'd1024, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  line_st;
  logic        sof_stb;
  logic [10:0] sof_frame;
  logic        usr_resume;
  logic [10:0] frm_cmp;
  logic [5:0]  flag_mask;
  logic [5:0]  flag_clr;
  logic [5:0]  flags;
  logic        irq;
  logic [10:0] frame_num;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  usb_bus_monitor #(
    .RST_CYC(RST_CYC), .IDLE_CYC(IDLE_CYC),
    .FRAME_CYC(FRAME_CYC), .SOF_SLACK(SOF_SLACK)
  ) uut (
    .clk(clk), .rst_n(rst_n), .line_st(line_st), .sof_stb(sof_stb),
    .sof_frame(sof_frame), .usr_resume(usr_resume), .frm_cmp(frm_cmp),
    .flag_mask(flag_mask), .flag_clr(flag_clr), .flags(flags), .irq(irq),
    .frame_num(frame_num)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    flag_clr = 6'h3F;
    tick(1);
    flag_clr = 6'h00;
  endtask

  task automatic pulse_sof(input logic [10:0] fr);
    sof_frame = fr;
    sof_stb   = 1'b1;
    tick(1);
    sof_stb   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; line_st = LK; sof_stb = 1'b0; sof_frame = '0;
    usr_resume = 1'b0; frm_cmp = '0; flag_mask = '0; flag_clr = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9 / R6 reset state
    check("R9 flags after reset", flags, 0);
    check("R10 irq after reset", irq, 0);
    check("R6 frame after reset", frame_num, 0);

    // R6 / R8 table of received frames against compare values
    for (int i = 0; i < 5; i++) begin
      clear_all();
      frm_cmp = VEC[i][11:1];
      pulse_sof(VEC[i][22:12]);
      check("R6 sof flag", flags[3], 1);
      check("R6 frame load", frame_num, VEC[i][22:12]);
      check("R8 match flag", flags[5], VEC[i][0]);
    end

    // R7 artificial SOF with wrap, R8 match on synthesized frame
    clear_all();
    frm_cmp = 11'd0;
    pulse_sof(11'd2047);
    clear_all();
    tick(LIMIT - 2);
    check("R7 no asof before window", flags[4], 0);
    tick(1);
    check("R7 asof flag", flags[4], 1);
    check("R7 frame wraps", frame_num, 0);
    check("R8 match on asof", flags[5], 1);
    clear_all();
    tick(FRAME_CYC - 2);
    check("R7 second asof not early", flags[4], 0);
    tick(1);
    check("R7 second asof", flags[4], 1);
    check("R7 frame steps", frame_num, 1);

    // R1 bus reset threshold, R11 disarm
    clear_all();
    line_st = SE0;
    tick(RST_CYC - 1);
    check("R1 no reset before threshold", flags[0], 0);
    tick(1);
    check("R1 reset flag", flags[0], 1);
    clear_all();
    tick(3);
    check("R1 once per episode", flags[0], 0);
    line_st = LK;
    clear_all();
    tick(LIMIT + 5);
    check("R11 no asof after bus reset", flags[4], 0);
    check("R11 frame held", frame_num, 1);

    // R1 short SE0
    line_st = SE0;
    tick(RST_CYC - 1);
    line_st = LK;
    tick(2);
    check("R1 short SE0 ignored", flags[0], 0);

    // R2 suspend and restart of idle count
    line_st = LJ;
    tick(20);
    line_st = LK;
    tick(1);
    check("R3 K not suspended no resume", flags[2], 0);
    line_st = LJ;
    tick(IDLE_CYC - 1);
    check("R2 idle restarted", flags[1], 0);
    tick(1);
    check("R2 suspend flag", flags[1], 1);

    // R3 resume from suspend
    line_st = LK;
    tick(1);
    check("R3 resume flag", flags[2], 1);
    clear_all();
    tick(2);
    check("R3 K after resume ignored", flags[2], 0);

    // R5 reset leaves suspend
    line_st = LJ;
    tick(IDLE_CYC);
    check("R5 suspended again", flags[1], 1);
    line_st = SE0;
    tick(RST_CYC);
    check("R5 reset flag", flags[0], 1);
    clear_all();
    line_st = LK;
    tick(2);
    check("R5 no resume after reset", flags[2], 0);

    // R4 user resume, R9 set wins over clear
    usr_resume = 1'b1;
    flag_clr   = 6'b000100;
    tick(1);
    usr_resume = 1'b0;
    flag_clr   = 6'b000000;
    check("R4 user resume flag", flags[2], 1);
    check("R9 set wins over clear", flags[2], 1);
    tick(3);
    check("R9 sticky", flags, 6'b000100);

    // R10 mask
    flag_mask = 6'b000100;
    tick(1);
    check("R10 irq enabled", irq, 1);
    flag_mask = 6'b111011;
    tick(1);
    check("R10 irq masked", irq, 0);
    flag_clr = 6'b000100;
    tick(1);
    flag_clr = 6'b000000;
    flag_mask = 6'b111111;
    tick(1);
    check("R9 cleared", flags, 0);
    check("R10 irq low no flags", irq, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule